// File: doc/BRIEF.md
# Smart-Card Interface Configuration Latch

This block holds the host-programmed configuration of a smart-card interface: the card supply selection, the card clock divider, the card clock run/stop mode and the polarity of the card-detect input. The host has no dedicated data bus for it. It presents the configuration on four shared pins: two address lines plus the data and reset lines, which stop acting as card signals while a program cycle is open. Chip select and a program-enable strobe frame each cycle.

A program cycle opens when chip select falls while program-enable is low. Once the cycle is open, program-enable may return high at any point. While chip select stays low, the address picks one configuration field and the data and reset lines carry its value. These bits may change together or one at a time. The value on the pins when chip select rises is written into the field, and the cycle closes at that moment. A chip-select pulse that falls with program-enable high is an ordinary select: its rising edge writes nothing. Every rising edge of chip select clears a pending interrupt. While a program cycle is open, the effective supply request is forced off.

All six host pins pass through a two-flop synchronizer, and edges are detected in the system clock domain. A small state machine tracks the chip-select cycle. Its states are `ST_IDLE` (chip select high), `ST_SELECTED` (chip select low, no program cycle) and `ST_PROGRAM` (program cycle open). It has four transitions. `ST_IDLE`→`ST_PROGRAM` is taken on a falling edge with program-enable low. `ST_IDLE`→`ST_SELECTED` is taken on a falling edge with program-enable high. `ST_PROGRAM`→`ST_IDLE` is taken on a rising edge and commits the write. `ST_SELECTED`→`ST_IDLE` is taken on a rising edge and writes nothing.

Top module: `cardif_cfg_latch`

## Requirements
- R1: After reset the outputs are as follows. `supply_sel`=00 (off). `clk_div`=11 (slowest). `clk_mode`=00 (stopped low). `det_pol`=0 (active-low). `prog_active`=0 and `irq`=0.
- R2: A falling edge of `cs_n` seen while `pgm_n` is low raises `prog_active`.
- R3: Once `prog_active` is set, a return of `pgm_n` to high before `cs_n` rises does not close the cycle, and the rising edge still commits the write.
- R4: On the `cs_n` rising edge that closes a program cycle, the 2-bit value `{rst_line, io_line}` is written into the field chosen by `{addr_hi, addr_lo}`. Code 00 selects `supply_sel`, 01 selects `clk_div`, 10 selects `clk_mode`, and 11 selects `det_pol`, which takes `io_line` only.
- R5: A commit changes only the addressed field, and the configuration outputs never change except on a committing `cs_n` rising edge.
- R6: A `cs_n` pulse that falls with `pgm_n` high writes nothing, even if `pgm_n` goes low while `cs_n` is low.
- R7: `prog_active` clears on the `cs_n` rising edge that closes the cycle.
- R8: A pulse on `irq_set` raises `irq`. Any `cs_n` rising edge clears `irq`. When both occur in the same cycle, the set wins.
- R9: While `prog_active` is high `supply_eff` is 00. Otherwise it equals `supply_sel`.
- R10: The values on the address and data lines at the `cs_n` rising edge are the ones stored. Bits may change one at a time while `cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| pgm_n | input | 1 | Program-enable strobe, active low, asynchronous |
| addr_lo | input | 1 | Field select, low bit |
| addr_hi | input | 1 | Field select, high bit |
| io_line | input | 1 | Configuration data, low bit |
| rst_line | input | 1 | Configuration data, high bit |
| irq_set | input | 1 | Interrupt request from the interface, one clock wide |
| supply_sel | output | 2 | Stored supply code |
| clk_div | output | 2 | Stored card clock divider code |
| clk_mode | output | 2 | Stored card clock mode code |
| det_pol | output | 1 | Stored card-detect polarity (1 = active-high) |
| supply_eff | output | 2 | Supply request after forcing off during programming |
| prog_active | output | 1 | A program cycle is open |
| irq | output | 1 | Pending interrupt |

## Verification
A host pin change reaches the outputs through three registers: two synchronizer flops and then the state, field or interrupt register. The change is therefore visible after the third rising clock edge that follows it. The bench drives pins on falling edges, waits four rising edges, and samples on the next falling edge, so every check lands at least one cycle after its result is due. The one exact-cycle case is the set-versus-clear race on `irq`. There, `irq_set` is driven on the falling edge after the second rising edge that follows the `cs_n` rise, so that it coincides with the clear.

// File: rtl/cardif_cfg_pkg.sv
package cardif_cfg_pkg;

    localparam int FIELD_W   = 2;
    localparam int ADDR_W    = 2;
    localparam int PIN_COUNT = 6;

    // positions inside the synchronized pin vector
    localparam int PIN_CS   = 0;
    localparam int PIN_PGM  = 1;
    localparam int PIN_A0   = 2;
    localparam int PIN_A1   = 3;
    localparam int PIN_IO   = 4;
    localparam int PIN_RST  = 5;

    // strobes idle high, data idle low
    localparam logic [PIN_COUNT-1:0] PIN_IDLE = 6'b000011;

    typedef enum logic [ADDR_W-1:0] {
        FLD_SUPPLY = 2'b00,
        FLD_DIV    = 2'b01,
        FLD_MODE   = 2'b10,
        FLD_POL    = 2'b11
    } field_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_SELECTED = 2'b01,
        ST_PROGRAM  = 2'b10
    } sel_state_e;

    localparam logic [FIELD_W-1:0] SUPPLY_RST = 2'b00;
    localparam logic [FIELD_W-1:0] DIV_RST    = 2'b11;
    localparam logic [FIELD_W-1:0] MODE_RST   = 2'b00;
    localparam logic               POL_RST    = 1'b0;

endpackage

// File: rtl/cardif_cfg_sync.sv
module cardif_cfg_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RESET_VAL;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RESET_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/cardif_cfg_fsm.sv
module cardif_cfg_fsm
    import cardif_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic pgm_s,
    output logic cs_rise,
    output logic cs_fall,
    output logic commit,
    output logic prog_active
);

    logic       cs_prev;
    sel_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_prev <= 1'b1;
        else        cs_prev <= cs_s;
    end

    assign cs_rise = cs_s & ~cs_prev;
    assign cs_fall = ~cs_s & cs_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_fall) state_d = pgm_s ? ST_SELECTED : ST_PROGRAM;
            end
            ST_SELECTED: begin
                if (cs_rise) state_d = ST_IDLE;
            end
            ST_PROGRAM: begin
                if (cs_rise) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        prog_active = 1'b0;
        commit      = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_SELECTED: ;
            ST_PROGRAM: begin
                prog_active = 1'b1;
                commit      = cs_rise;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cardif_cfg_fields.sv
module cardif_cfg_fields
    import cardif_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [FIELD_W-1:0] wdata,
    output logic [FIELD_W-1:0] supply_sel,
    output logic [FIELD_W-1:0] clk_div,
    output logic [FIELD_W-1:0] clk_mode,
    output logic               det_pol
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            supply_sel <= SUPPLY_RST;
            clk_div    <= DIV_RST;
            clk_mode   <= MODE_RST;
            det_pol    <= POL_RST;
        end else if (commit) begin
            unique case (field_sel_e'(addr))
                FLD_SUPPLY: supply_sel <= wdata;
                FLD_DIV:    clk_div    <= wdata;
                FLD_MODE:   clk_mode   <= wdata;
                FLD_POL:    det_pol    <= wdata[0];
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/cardif_cfg_irq.sv
module cardif_cfg_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_set,
    input  logic cs_rise,
    output logic irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       irq <= 1'b0;
        else if (irq_set) irq <= 1'b1;
        else if (cs_rise) irq <= 1'b0;
    end

endmodule

// File: rtl/cardif_cfg_latch.sv
module cardif_cfg_latch
    import cardif_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       pgm_n,
    input  logic       addr_lo,
    input  logic       addr_hi,
    input  logic       io_line,
    input  logic       rst_line,
    input  logic       irq_set,
    output logic [1:0] supply_sel,
    output logic [1:0] clk_div,
    output logic [1:0] clk_mode,
    output logic       det_pol,
    output logic [1:0] supply_eff,
    output logic       prog_active,
    output logic       irq
);

    logic [PIN_COUNT-1:0] pins_raw, pins_s;
    logic                 cs_rise, cs_fall, commit;

    assign pins_raw = {rst_line, io_line, addr_hi, addr_lo, pgm_n, cs_n};

    cardif_cfg_sync #(
        .WIDTH     (PIN_COUNT),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (PIN_IDLE)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_raw),
        .sync_out (pins_s)
    );

    cardif_cfg_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s        (pins_s[PIN_CS]),
        .pgm_s       (pins_s[PIN_PGM]),
        .cs_rise     (cs_rise),
        .cs_fall     (cs_fall),
        .commit      (commit),
        .prog_active (prog_active)
    );

    cardif_cfg_fields fields_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .addr       ({pins_s[PIN_A1], pins_s[PIN_A0]}),
        .wdata      ({pins_s[PIN_RST], pins_s[PIN_IO]}),
        .supply_sel (supply_sel),
        .clk_div    (clk_div),
        .clk_mode   (clk_mode),
        .det_pol    (det_pol)
    );

    cardif_cfg_irq irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_set (irq_set),
        .cs_rise (cs_rise),
        .irq     (irq)
    );

    assign supply_eff = prog_active ? SUPPLY_RST : supply_sel;

endmodule

// File: rtl/cardif_cfg_latch_chk.sv
module cardif_cfg_latch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_rise,
    input logic       cs_fall,
    input logic       pgm_s,
    input logic       irq_set,
    input logic       irq,
    input logic       prog_active,
    input logic [1:0] supply_sel,
    input logic [1:0] clk_div,
    input logic [1:0] clk_mode,
    input logic       det_pol
);

    // R2
    prog_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall && !pgm_s |=> prog_active);

    // R7
    prog_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !prog_active);

    // R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> irq);

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise && !irq_set |=> !irq);

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable({supply_sel, clk_div, clk_mode, det_pol}));

    // R6
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise && !prog_active |=> $stable({supply_sel, clk_div, clk_mode, det_pol}));

endmodule

bind cardif_cfg_latch cardif_cfg_latch_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_rise     (cs_rise),
    .cs_fall     (cs_fall),
    .pgm_s       (pins_s[1]),
    .irq_set     (irq_set),
    .irq         (irq),
    .prog_active (prog_active),
    .supply_sel  (supply_sel),
    .clk_div     (clk_div),
    .clk_mode    (clk_mode),
    .det_pol     (det_pol)
);

// File: tb/cardif_cfg_latch_tb.sv
module cardif_cfg_latch_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, pgm_n = 1'b1;
    logic       addr_lo = 1'b0, addr_hi = 1'b0, io_line = 1'b0, rst_line = 1'b0;
    logic       irq_set = 1'b0;
    logic [1:0] supply_sel, clk_div, clk_mode, supply_eff;
    logic       det_pol, prog_active, irq;

    int checks = 0;
    int failures = 0;
    logic [1:0] m_sup = 2'b00, m_div = 2'b11, m_mode = 2'b00;
    logic       m_pol = 1'b0;

    always #2.5 clk = ~clk;

    cardif_cfg_latch dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .pgm_n(pgm_n),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .io_line(io_line), .rst_line(rst_line),
        .irq_set(irq_set), .supply_sel(supply_sel), .clk_div(clk_div),
        .clk_mode(clk_mode), .det_pol(det_pol), .supply_eff(supply_eff),
        .prog_active(prog_active), .irq(irq)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_cfg(input string req);
        check({req, " supply_sel"}, supply_sel, m_sup);
        check({req, " clk_div"}, clk_div, m_div);
        check({req, " clk_mode"}, clk_mode, m_mode);
        check({req, " det_pol"}, det_pol, m_pol);
    endtask

    // one chip-select cycle; bits are presented one at a time while cs_n is low (R10)
    task automatic cs_cycle(input logic [1:0] a, input logic [1:0] d,
                            input bit prog, input bit late_pgm, input bit release_pgm);
        @(negedge clk);
        pgm_n = prog ? 1'b0 : 1'b1;
        addr_lo = ~a[0]; addr_hi = ~a[1]; io_line = ~d[0]; rst_line = ~d[1];
        settle();
        cs_n = 1'b0;
        settle();
        check("R2 prog_active after fall", prog_active, prog);
        if (late_pgm) begin
            pgm_n = 1'b0;
            settle();
            check("R6 late pgm ignored", prog_active, 0);
        end
        if (prog && release_pgm) begin
            pgm_n = 1'b1;
            settle();
            check("R3 cycle survives pgm release", prog_active, 1);
        end
        addr_lo = a[0];  @(negedge clk);
        addr_hi = a[1];  @(negedge clk);
        io_line = d[0];  @(negedge clk);
        rst_line = d[1]; settle();
        if (prog) check("R9 supply_eff off while programming", supply_eff, 0);
        cs_n = 1'b1;
        settle();
        pgm_n = 1'b1;
        if (prog) begin
            unique case (a)
                2'b00: m_sup = d;
                2'b01: m_div = d;
                2'b10: m_mode = d;
                default: m_pol = d[0];
            endcase
        end
        check("R7 prog_active cleared", prog_active, 0);
        check_cfg(prog ? "R4 R5 R10 write" : "R6 no write");
        check("R9 supply_eff follows", supply_eff, m_sup);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired got=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1
        check_cfg("R1 reset");
        check("R1 prog_active", prog_active, 0);
        check("R1 irq", irq, 0);

        // exhaustive sweep of field x value, alternating pgm release (R3, R4, R5)
        for (int a = 0; a < 4; a++)
            for (int d = 0; d < 4; d++)
                cs_cycle(a[1:0], d[1:0], 1'b1, 1'b0, d[0]);

        // non-program pulses, including late pgm, must write nothing (R6)
        for (int a = 0; a < 4; a++)
            cs_cycle(a[1:0], ~m_sup, 1'b0, a[0], 1'b0);

        // R8 set, then clear by a plain chip-select pulse
        @(negedge clk); irq_set = 1'b1;
        @(negedge clk); irq_set = 1'b0;
        settle();
        check("R8 irq raised", irq, 1);
        cs_n = 1'b0; settle();
        check("R8 irq holds while cs low", irq, 1);
        cs_n = 1'b1; settle();
        check("R8 irq cleared by cs rise", irq, 0);

        // R8 set and clear in the same cycle: set wins
        @(negedge clk); irq_set = 1'b1;
        @(negedge clk); irq_set = 1'b0;
        cs_n = 1'b0; settle();
        cs_n = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); irq_set = 1'b1;
        @(negedge clk); irq_set = 1'b0;
        settle();
        check("R8 set wins over clear", irq, 1);

        // clear through a program cycle too
        cs_cycle(2'b01, 2'b10, 1'b1, 1'b0, 1'b1);
        check("R8 irq cleared by program cycle", irq, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule